// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block models the read side of a 16-bit memory that is read in bursts. A host pulses an address strobe with a start address. The sequencer then waits a programmable number of clocks for the initial access and after that presents one word per clock. A ready output tells the host when a word is on the bus. The stored words come from a fixed content pattern that is computed inside the block, so each address has its own known value.

The burst order is set by a mode field. In linear order the address simply counts up, and extra wait cycles are inserted each time the burst leaves a 64-word block. In the three wrap orders the address stays inside an aligned group of 8, 16 or 32 words. A handshake option shortens the initial latency for even start addresses. Another option moves ready one clock ahead of the data. While output enable is low during a burst, the burst holds its place, and it continues once output enable returns.

The sequencer has five states. S_IDLE means no burst. S_WAIT counts the initial latency. S_BURST presents words. S_BWAIT holds the boundary gap. S_SUSP holds a frozen burst. The transitions are as follows. A strobe leads from any state to S_WAIT. S_WAIT goes to S_BURST when its count reaches zero. S_BURST goes to S_BWAIT after the last word of a 64-word block, and to S_SUSP when output enable is low. S_BWAIT goes back to S_BURST when its count reaches zero. S_SUSP goes to S_BURST when output enable returns. Asynchronous mode sends the machine from any state to S_IDLE.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, `ready` is low and `rdata` is zero until a strobe is accepted.
- R2: A clock edge that samples `addr_strobe` high (with `async_mode` low) latches `addr`. The first word appears L+1 clocks after that edge. L is the clamped wait code (codes 0 to 5 give themselves, and codes 6 and 7 give 5) plus one in standard handshake (`reduced_hs` = 0).
- R3: With `reduced_hs` = 1, an even start address uses L equal to the clamped code, and an odd start address uses the clamped code plus one.
- R4: With `burst_mode` = 0 (linear), successive words come from successive addresses, and the address rolls over from the top address to zero.
- R5: In linear mode, after the word at an address whose low six bits are all ones, `BOUND_WAIT` (default 2) clocks pass with no word before the next word. This includes the rollover to zero.
- R6: `burst_mode` 1, 2 and 3 wrap the low 3, 4 or 5 address bits, incrementing them modulo 8, 16 or 32 while the upper bits stay fixed. These modes have no boundary gaps.
- R7: With `ready_early` = 0, `ready` is high exactly in the clocks where a word is presented. With `ready_early` = 1, `ready` is high one clock before each presented word.
- R8: A word is presented only in S_BURST with `out_en` high. Its value is 16'hC3A5 ^ (a << 3) ^ a for address a, zero-extended. At all other times `rdata` is zero.
- R9: Holding `out_en` low for N clocks right after a word freezes the burst address. The next word is the following address, and it arrives N+1 clocks later than it otherwise would, with no new initial latency.
- R10: A strobe during a burst abandons it and restarts with the new address and a full initial latency.
- R11: While `async_mode` is high, the sequencer stays idle, strobes are ignored, `ready` is low and no word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_strobe | input | 1 | Start-address valid strobe |
| addr | input | ADDR_W | Burst start address |
| out_en | input | 1 | Output enable; low suspends a burst |
| async_mode | input | 1 | 1 disables burst operation |
| burst_mode | input | 2 | 0 linear, 1 wrap 8, 2 wrap 16, 3 wrap 32 |
| wait_code | input | 3 | Initial wait-state code |
| ready_early | input | 1 | 1 raises ready one clock ahead of data |
| reduced_hs | input | 1 | 1 shortens latency for even start addresses |
| ready | output | 1 | Data-ready indication |
| rdata | output | 16 | Presented word, zero when none |

## Verification
Directed bursts start just below a 64-word boundary and at the top address, to show the gap length and the rollover. Wrap bursts start at unaligned addresses that cross a 3Fh address, to show that the group edge is kept and that no gap appears. Even and odd start addresses under both handshake options separate the two latency rules. A strobe issued in the middle of a burst, and an asynchronous-mode window with a strobe inside it, show the abort and ignore cases. Seeded random bursts then mix every mode, wait code, ready timing and suspension length. Each one is checked word by word, and the clock at which each word appears is compared with a timeline the bench builds from the requirements.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_BURST,
        S_BWAIT,
        S_SUSP
    } seq_state_t;

    typedef enum logic [1:0] {
        M_LINEAR = 2'd0,
        M_WRAP8  = 2'd1,
        M_WRAP16 = 2'd2,
        M_WRAP32 = 2'd3
    } rd_mode_t;
endpackage

// File: rtl/burst_lat_calc.sv
module burst_lat_calc #(
    parameter int CNT_W = 3
) (
    input  logic [2:0]       wait_code,
    input  logic             reduced_hs,
    input  logic             start_odd,
    output logic [CNT_W-1:0] init_count
);
    logic [2:0] clamped;

    always_comb begin
        clamped = (wait_code > 3'd5) ? 3'd5 : wait_code;
        init_count = CNT_W'(clamped) + CNT_W'(!reduced_hs || start_odd);
    end
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BND_BITS = 6
) (
    input  logic [ADDR_W-1:0] cur,
    input  rd_mode_t          mode,
    output logic [ADDR_W-1:0] nxt,
    output logic              at_boundary
);
    logic [ADDR_W-1:0] wrap_cand [3];

    for (genvar g = 0; g < 3; g++) begin : g_wrap
        localparam int K = 3 + g;
        assign wrap_cand[g] = {cur[ADDR_W-1:K], cur[K-1:0] + K'(1)};
    end

    always_comb begin
        unique case (mode)
            M_LINEAR: nxt = cur + ADDR_W'(1);
            M_WRAP8:  nxt = wrap_cand[0];
            M_WRAP16: nxt = wrap_cand[1];
            M_WRAP32: nxt = wrap_cand[2];
        endcase
        at_boundary = (mode == M_LINEAR) && (&cur[BND_BITS-1:0]);
    end
endmodule

// File: rtl/burst_word_rom.sv
module burst_word_rom
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] a,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] ext;

    always_comb begin
        ext  = WORD_W'(a);
        word = 16'hC3A5 ^ (ext << 3) ^ ext;
    end
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BOUND_SPAN = 64,
    parameter int BOUND_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic              out_en,
    input  logic              async_mode,
    input  logic [1:0]        burst_mode,
    input  logic [2:0]        wait_code,
    input  logic              ready_early,
    input  logic              reduced_hs,
    output logic              ready,
    output logic [15:0]       rdata
);
    localparam int BND_BITS = $clog2(BOUND_SPAN);
    localparam int CNT_MAX  = (BOUND_WAIT - 1 > 6) ? BOUND_WAIT - 1 : 6;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    seq_state_t        state_q, state_d;
    rd_mode_t          mode_q;
    logic [ADDR_W-1:0] cur_q, step_addr;
    logic [CNT_W-1:0]  cnt_q, init_count;
    logic              at_boundary, start_ok, present;
    logic [WORD_W-1:0] word;

    burst_lat_calc #(.CNT_W(CNT_W)) u_lat (
        .wait_code (wait_code),
        .reduced_hs(reduced_hs),
        .start_odd (addr[0]),
        .init_count(init_count)
    );

    burst_addr_step #(.ADDR_W(ADDR_W), .BND_BITS(BND_BITS)) u_step (
        .cur        (cur_q),
        .mode       (mode_q),
        .nxt        (step_addr),
        .at_boundary(at_boundary)
    );

    burst_word_rom #(.ADDR_W(ADDR_W)) u_rom (
        .a   (cur_q),
        .word(word)
    );

    assign start_ok = addr_strobe && !async_mode;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (async_mode) begin
            state_d = S_IDLE;
        end else if (addr_strobe) begin
            state_d = S_WAIT;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_WAIT:  state_d = (cnt_q == '0) ? S_BURST : S_WAIT;
                S_BURST: state_d = !out_en ? S_SUSP : (at_boundary ? S_BWAIT : S_BURST);
                S_BWAIT: state_d = (cnt_q == '0) ? S_BURST : S_BWAIT;
                S_SUSP:  state_d = out_en ? S_BURST : S_SUSP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // burst position and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            cnt_q  <= '0;
            mode_q <= M_LINEAR;
        end else if (start_ok) begin
            cur_q  <= addr;
            cnt_q  <= init_count;
            mode_q <= rd_mode_t'(burst_mode);
        end else if (!async_mode) begin
            unique case (state_q)
                S_WAIT, S_BWAIT: begin
                    if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
                end
                S_BURST: begin
                    if (out_en) begin
                        cur_q <= step_addr;
                        if (at_boundary) cnt_q <= CNT_W'(BOUND_WAIT - 1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        present = (state_q == S_BURST) && out_en;
        rdata   = present ? word : '0;
        ready   = ready_early ? (state_d == S_BURST) : present;
    end

    // R2: an accepted strobe always enters the initial wait
    p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (state_q == S_WAIT));

    // R11: asynchronous mode parks the machine with ready low
    p_async_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        async_mode |=> (state_q == S_IDLE && !ready && rdata == '0));

    // R9: a burst with output enable low keeps its position
    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BURST && !out_en && !addr_strobe && !async_mode)
        |=> (state_q == S_SUSP && $stable(cur_q)));

    // R5: leaving a 64-word block in linear order enters the gap
    p_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BURST && out_en && !addr_strobe && !async_mode
         && mode_q == M_LINEAR && (&cur_q[BND_BITS-1:0]))
        |=> (state_q == S_BWAIT && rdata == '0));

    // R6: wrap orders keep the upper address bits and never gap
    p_wrap_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BURST && out_en && !addr_strobe && !async_mode
         && mode_q != M_LINEAR)
        |=> (state_q == S_BURST && cur_q[ADDR_W-1:5] == $past(cur_q[ADDR_W-1:5])));
endmodule

// File: tb/test_burst_read_seq.sv
`timescale 1ns/1ps
module test_burst_read_seq;
    localparam int BW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_strobe = 1'b0;
    logic [7:0]  addr = '0;
    logic        out_en = 1'b1;
    logic        async_mode = 1'b0;
    logic [1:0]  burst_mode = '0;
    logic [2:0]  wait_code = '0;
    logic        ready_early = 1'b0;
    logic        reduced_hs = 1'b0;
    logic        ready;
    logic [15:0] rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int last_first_s, last_exp_first;

    always #2.5 clk = ~clk;

    burst_read_seq #(.ADDR_W(8), .BOUND_SPAN(64), .BOUND_WAIT(BW)) i_burst_read_seq (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .addr(addr),
        .out_en(out_en), .async_mode(async_mode), .burst_mode(burst_mode),
        .wait_code(wait_code), .ready_early(ready_early), .reduced_hs(reduced_hs),
        .ready(ready), .rdata(rdata)
    );

    function automatic logic [15:0] word_of(logic [7:0] a);
        return 16'hC3A5 ^ ({8'h00, a} << 3) ^ {8'h00, a};
    endfunction

    function automatic logic [7:0] step_of(logic [7:0] a, int mode);
        case (mode)
            0:       return a + 8'd1;
            1:       return {a[7:3], a[2:0] + 3'd1};
            2:       return {a[7:4], a[3:0] + 4'd1};
            default: return {a[7:5], a[4:0] + 5'd1};
        endcase
    endfunction

    function automatic int lat_of(int code, bit red, bit odd);
        int w;
        w = (code > 5) ? 5 : code;
        return w + ((!red || odd) ? 1 : 0);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run_burst(logic [7:0] a, int mode, int code, bit red, bit early,
                             int n, int susp_k, int susp_len);
        int s, got, exp_s, srem, first_s, bad_word, bad_time, bad_rdy;
        int wa, we;
        logic [7:0] ea;
        bit pres, prev_rdy;
        @(negedge clk);
        addr = a; burst_mode = 2'(mode); wait_code = 3'(code);
        reduced_hs = red; ready_early = early; addr_strobe = 1'b1; out_en = 1'b1;
        exp_s = lat_of(code, red, a[0]) + 1;
        last_exp_first = exp_s;
        s = 0; got = 0; srem = 0; first_s = -1; ea = a; prev_rdy = 1'b0;
        bad_word = 0; bad_time = 0; bad_rdy = 0; wa = 0; we = 0;
        while (got < n && s < 2000) begin
            @(negedge clk);
            addr_strobe = 1'b0;
            if (srem > 0) begin out_en = 1'b0; srem--; end
            else out_en = 1'b1;
            #1;
            pres = (rdata != 16'h0000);
            if (early) begin
                if (s > 0 && out_en && (prev_rdy != pres)) bad_rdy++;
            end else if (ready != pres) bad_rdy++;
            prev_rdy = ready;
            if (pres) begin
                if (got == 0) first_s = s;
                if (rdata != word_of(ea)) begin
                    if (bad_word == 0) begin wa = int'(rdata); we = int'(word_of(ea)); end
                    bad_word++;
                end
                if (s != exp_s) bad_time++;
                exp_s = s + 1;
                if (mode == 0 && ea[5:0] == 6'h3F) exp_s += BW;
                if (got == susp_k) begin srem = susp_len; exp_s += susp_len + 1; end
                ea = step_of(ea, mode);
                got++;
            end
            s++;
        end
        last_first_s = first_s;
        chk(first_s == last_exp_first, red ? "R3" : "R2", "first word clock",
            first_s, last_exp_first);
        chk(bad_word == 0, (mode == 0) ? "R4 R8" : "R6 R8", "word value", wa, we);
        chk(bad_time == 0, (susp_k >= 0) ? "R9" : ((mode == 0) ? "R5" : "R6"),
            "mistimed words", bad_time, 0);
        chk(bad_rdy == 0, "R7", "ready misaligned clocks", bad_rdy, 0);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int bad, k, len, n;
        logic [7:0] a, t;
        int mode, code;
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        #1;
        chk(ready == 1'b0 && rdata == 16'h0, "R1", "outputs in reset", int'(rdata), 0);
        @(negedge clk); rst_n = 1'b1;
        bad = 0;
        repeat (4) begin @(negedge clk); #1; if (ready || rdata != 0) bad++; end
        chk(bad == 0, "R1", "quiet after reset", bad, 0);

        // directed corner cases
        run_burst(8'h3C, 0, 2, 0, 0, 8, -1, 0);   // R5 gap at 3F
        run_burst(8'hFE, 0, 5, 0, 0, 5, -1, 0);   // R4 R5 rollover to 00
        run_burst(8'h1D, 1, 0, 0, 0, 12, -1, 0);  // R6 wrap 8
        run_burst(8'h3A, 2, 3, 0, 1, 20, -1, 0);  // R6 wrap 16, early ready
        run_burst(8'h3E, 3, 7, 0, 0, 40, -1, 0);  // R6 wrap 32 across 3F
        run_burst(8'h20, 0, 4, 1, 0, 4, -1, 0);   // R3 even
        run_burst(8'h21, 0, 4, 1, 0, 4, -1, 0);   // R3 odd
        run_burst(8'h50, 0, 1, 0, 1, 10, 3, 3);   // R9 suspend, early ready
        run_burst(8'h10, 0, 2, 0, 0, 3, -1, 0);   // burst left running
        run_burst(8'h80, 0, 3, 0, 0, 6, -1, 0);   // R10 restart
        chk(last_first_s == last_exp_first, "R10", "restart latency",
            last_first_s, last_exp_first);

        // R11: asynchronous mode halts and ignores strobes
        @(negedge clk); async_mode = 1'b1; out_en = 1'b1;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            addr_strobe = (i == 2);
            addr = 8'h44;
            #1;
            if (i > 0 && (ready || rdata != 0)) bad++;
        end
        chk(bad == 0, "R11", "activity in async mode", bad, 0);
        @(negedge clk); addr_strobe = 1'b0; async_mode = 1'b0;
        bad = 0;
        repeat (10) begin @(negedge clk); #1; if (ready || rdata != 0) bad++; end
        chk(bad == 0, "R11", "ignored strobe started a burst", bad, 0);

        // seeded random bursts
        for (int it = 0; it < 40; it++) begin
            a = 8'($urandom % 256);
            mode = int'($urandom % 4);
            code = int'($urandom % 8);
            n = 1 + int'($urandom % 80);
            k = -1; len = 0;
            if ($urandom % 3 == 0) begin
                k = int'($urandom % n);
                len = 1 + int'($urandom % 4);
                t = a;
                for (int j = 0; j < k; j++) t = step_of(t, mode);
                if (mode == 0 && t[5:0] == 6'h3F) k = -1;
            end
            run_burst(a, mode, code, 1'($urandom % 2), 1'($urandom % 2), n, k, len);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule